// File: doc/BRIEF.md
# Store-Set Memory Dependence Predictor

This block tells an out-of-order core which earlier store a memory instruction should wait for. A PC-indexed identifier table assigns instructions to store sets, and each table entry has a valid bit. A second table, indexed by set number, holds the sequence number of the youngest fetched store of each set, with a valid bit. Each set also has a saturating population counter.

Training happens when a memory-order violation is reported. The load and the store are placed in a common set. When both already belong to sets, the smaller set is merged into the larger one, judged by the counters. Fetched stores record themselves in their set's entry. A lookup returns the sequence number to wait on, or 0 when there is no dependence. Store issue, squash and a global clear retire recorded stores.

Top module: `sset_predictor`

## Requirements
- R1: After reset every lookup returns 0 and all population counters are zero.
- R2: The identifier table entry is selected by PC bits [IDX_W+1:2], so PC bits 1:0 and bits above IDX_W+1 are ignored. A newly created set number is load PC bits [SID_W+1:2].
- R3: On a violation where neither the load nor the store has a valid identifier, both entries receive the new set number and are marked valid, and that set's counter increments.
- R4: On a violation where only the load has a valid identifier, the store joins the load's set and that counter increments. Where only the store has one, the load joins the store's set and no counter changes.
- R5: On a violation where both have valid identifiers, the store moves into the load's set if the load set's counter is strictly greater than the store set's counter. Otherwise the load moves into the store's set. The receiving set's counter increments and the other set's counter decrements.
- R6: Counters saturate at 2^CNT_W-1, never go below zero, and keep their values across a clear.
- R7: A fetched store whose PC has a valid identifier writes its sequence number into its set's entry and marks it valid. A fetched store without an identifier, and any fetched load, leave the tables unchanged.
- R8: Within the same cycle, the lookup output is the recorded sequence number when the PC has a valid identifier and its set entry is valid. Otherwise it is 0.
- R9: An issued store whose set entry is valid and holds its own sequence number clears that entry. An issued store with a different number, and any issued load, change nothing.
- R10: A squash clears every valid set entry whose recorded sequence number is strictly below the squash number.
- R11: Clear invalidates every entry of both tables.
- R12: At most one operation is applied per cycle. The priority is clear, then violation, then squash, then store issue, then store fetch. Load fetch and load issue are not requests and block nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear_all | input | 1 | Invalidate both tables |
| train_valid | input | 1 | Violation report |
| train_store_pc | input | PC_W | PC of the violating store |
| train_load_pc | input | PC_W | PC of the violating load |
| fetch_valid | input | 1 | Memory instruction fetched |
| fetch_is_store | input | 1 | Fetched instruction is a store |
| fetch_pc | input | PC_W | PC of the fetched instruction |
| fetch_seq | input | SEQ_W | Sequence number of the fetched instruction |
| issue_valid | input | 1 | Memory instruction issued |
| issue_is_store | input | 1 | Issued instruction is a store |
| issue_pc | input | PC_W | PC of the issued instruction |
| issue_seq | input | SEQ_W | Sequence number of the issued instruction |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Squash sequence number |
| lookup_pc | input | PC_W | PC to query |
| lookup_dep_seq | output | SEQ_W | Store sequence number to wait on, 0 if none |

## Verification
A corrupted identifier entry shows up only indirectly. The next time a store of that set is fetched, a lookup of a related load returns the wrong number or 0, so the error is seen one cycle after that fetch. A wrong population counter can stay hidden much longer, because it becomes visible only when two populated sets later merge in the wrong direction. The stimulus therefore builds sets of known size, then merges them, clears them and saturates their counters. Afterwards it probes the load that must not have moved.

// File: rtl/sset_pkg.sv
package sset_pkg;
   typedef enum logic [2:0] {
      OP_NONE,
      OP_CLEAR,
      OP_TRAIN,
      OP_SQUASH,
      OP_ISSUE,
      OP_FETCH
   } sset_op_e;
endpackage

// File: rtl/sset_id_table.sv
module sset_id_table #(
   parameter int DEPTH = 64,
   parameter int ID_W  = 4,
   parameter int NRD   = 5,
   parameter int IDX_W = $clog2(DEPTH)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr_all,
   input  logic [NRD-1:0][IDX_W-1:0]  rd_idx,
   output logic [NRD-1:0]             rd_valid,
   output logic [NRD-1:0][ID_W-1:0]   rd_id,
   input  logic                       wa_en,
   input  logic [IDX_W-1:0]           wa_idx,
   input  logic [ID_W-1:0]            wa_id,
   input  logic                       wb_en,
   input  logic [IDX_W-1:0]           wb_idx,
   input  logic [ID_W-1:0]            wb_id,
   output logic [DEPTH-1:0]           valid_vec
);
   logic [DEPTH-1:0]           ent_v;
   logic [DEPTH-1:0][ID_W-1:0] ent_id;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_v  <= '0;
         ent_id <= '0;
      end else if (clr_all) begin
         ent_v <= '0;
      end else begin
         if (wa_en) begin
            ent_v[wa_idx]  <= 1'b1;
            ent_id[wa_idx] <= wa_id;
         end
         if (wb_en) begin
            ent_v[wb_idx]  <= 1'b1;
            ent_id[wb_idx] <= wb_id;
         end
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      assign rd_valid[p] = ent_v[rd_idx[p]];
      assign rd_id[p]    = ent_id[rd_idx[p]];
   end

   assign valid_vec = ent_v;
endmodule

// File: rtl/sset_last_store.sv
module sset_last_store #(
   parameter int DEPTH = 16,
   parameter int SEQ_W = 16,
   parameter int ID_W  = $clog2(DEPTH)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr_all,
   input  logic                        sq_en,
   input  logic [SEQ_W-1:0]            sq_seq,
   input  logic                        wr_en,
   input  logic [ID_W-1:0]             wr_id,
   input  logic [SEQ_W-1:0]            wr_seq,
   input  logic                        kill_en,
   input  logic [ID_W-1:0]             kill_id,
   input  logic [SEQ_W-1:0]            kill_seq,
   input  logic [ID_W-1:0]             rd_id,
   output logic                        rd_valid,
   output logic [SEQ_W-1:0]            rd_seq,
   output logic [DEPTH-1:0]            valid_vec,
   output logic [DEPTH-1:0][SEQ_W-1:0] seq_vec
);
   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic             v_q;
      logic [SEQ_W-1:0] s_q;
      logic             hit_wr, hit_kill;

      assign hit_wr   = wr_en && (wr_id == ID_W'(e));
      assign hit_kill = kill_en && (kill_id == ID_W'(e)) && (s_q == kill_seq);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            s_q <= '0;
         end else if (clr_all) begin
            v_q <= 1'b0;
         end else if (sq_en) begin
            if (s_q < sq_seq) v_q <= 1'b0;
         end else if (hit_kill) begin
            v_q <= 1'b0;
         end else if (hit_wr) begin
            v_q <= 1'b1;
            s_q <= wr_seq;
         end
      end

      assign valid_vec[e] = v_q;
      assign seq_vec[e]   = s_q;
   end

   assign rd_valid = valid_vec[rd_id];
   assign rd_seq   = seq_vec[rd_id];
endmodule

// File: rtl/sset_pop_counters.sv
module sset_pop_counters #(
   parameter int DEPTH = 16,
   parameter int CNT_W = 3,
   parameter int ID_W  = $clog2(DEPTH)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        inc_en,
   input  logic [ID_W-1:0]             inc_id,
   input  logic                        dec_en,
   input  logic [ID_W-1:0]             dec_id,
   output logic [DEPTH-1:0][CNT_W-1:0] cnt_vec
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   for (genvar e = 0; e < DEPTH; e++) begin : g_cnt
      logic [CNT_W-1:0] c_q;
      logic up, dn;

      assign up = inc_en && (inc_id == ID_W'(e));
      assign dn = dec_en && (dec_id == ID_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              c_q <= '0;
         else if (up && !dn && c_q != CNT_MAX)    c_q <= c_q + 1'b1;
         else if (dn && !up && c_q != '0)         c_q <= c_q - 1'b1;
      end

      assign cnt_vec[e] = c_q;
   end
endmodule

// File: rtl/sset_predictor.sv
module sset_predictor
   import sset_pkg::*;
#(
   parameter int PC_W      = 32,
   parameter int SEQ_W     = 16,
   parameter int IDT_DEPTH = 64,
   parameter int LST_DEPTH = 16,
   parameter int CNT_W     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_all,
   input  logic             train_valid,
   input  logic [PC_W-1:0]  train_store_pc,
   input  logic [PC_W-1:0]  train_load_pc,
   input  logic             fetch_valid,
   input  logic             fetch_is_store,
   input  logic [PC_W-1:0]  fetch_pc,
   input  logic [SEQ_W-1:0] fetch_seq,
   input  logic             issue_valid,
   input  logic             issue_is_store,
   input  logic [PC_W-1:0]  issue_pc,
   input  logic [SEQ_W-1:0] issue_seq,
   input  logic             squash_valid,
   input  logic [SEQ_W-1:0] squash_seq,
   input  logic [PC_W-1:0]  lookup_pc,
   output logic [SEQ_W-1:0] lookup_dep_seq
);
   localparam int IDX_W = $clog2(IDT_DEPTH);
   localparam int SID_W = $clog2(LST_DEPTH);
   localparam int NRD   = 5;
   localparam int RP_TL = 0, RP_TS = 1, RP_FE = 2, RP_IS = 3, RP_LK = 4;

   if (IDT_DEPTH < 2 || (IDT_DEPTH & (IDT_DEPTH - 1)) != 0) begin : g_bad_idt
      $error("identifier table depth must be a power of two of at least 2");
   end
   if (LST_DEPTH < 2 || (LST_DEPTH & (LST_DEPTH - 1)) != 0) begin : g_bad_lst
      $error("last-store table depth must be a power of two of at least 2");
   end
   if (PC_W < IDX_W + 2 || PC_W < SID_W + 2) begin : g_bad_pc
      $error("PC width too small for the table indices");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("population counter needs at least 2 bits");
   end

   sset_op_e op;
   always_comb begin
      if (clear_all)                          op = OP_CLEAR;
      else if (train_valid)                   op = OP_TRAIN;
      else if (squash_valid)                  op = OP_SQUASH;
      else if (issue_valid && issue_is_store) op = OP_ISSUE;
      else if (fetch_valid && fetch_is_store) op = OP_FETCH;
      else                                    op = OP_NONE;
   end

   logic [NRD-1:0][IDX_W-1:0] rd_idx;
   logic [NRD-1:0]            rd_valid;
   logic [NRD-1:0][SID_W-1:0] rd_id;
   assign rd_idx[RP_TL] = train_load_pc[IDX_W+1:2];
   assign rd_idx[RP_TS] = train_store_pc[IDX_W+1:2];
   assign rd_idx[RP_FE] = fetch_pc[IDX_W+1:2];
   assign rd_idx[RP_IS] = issue_pc[IDX_W+1:2];
   assign rd_idx[RP_LK] = lookup_pc[IDX_W+1:2];

   logic                        wa_en, wb_en, inc_en, dec_en;
   logic [SID_W-1:0]            wa_id, wb_id, inc_id, dec_id;
   logic [IDT_DEPTH-1:0]        idt_valid_vec;
   logic [LST_DEPTH-1:0]        lst_valid_vec;
   logic [LST_DEPTH-1:0][SEQ_W-1:0] lst_seq_vec;
   logic [LST_DEPTH-1:0][CNT_W-1:0] cnt_vec;
   logic [SID_W-1:0]            ld_id, st_id, new_id;
   logic                        ld_ok, st_ok;

   assign ld_id  = rd_id[RP_TL];
   assign st_id  = rd_id[RP_TS];
   assign ld_ok  = rd_valid[RP_TL];
   assign st_ok  = rd_valid[RP_TS];
   assign new_id = train_load_pc[SID_W+1:2];

   always_comb begin
      wa_en = 1'b0; wa_id = '0;
      wb_en = 1'b0; wb_id = '0;
      inc_en = 1'b0; inc_id = '0;
      dec_en = 1'b0; dec_id = '0;
      if (op == OP_TRAIN) begin
         unique case ({ld_ok, st_ok})
            2'b00: begin
               wa_en = 1'b1; wa_id = new_id;
               wb_en = 1'b1; wb_id = new_id;
               inc_en = 1'b1; inc_id = new_id;
            end
            2'b10: begin
               wb_en = 1'b1; wb_id = ld_id;
               inc_en = 1'b1; inc_id = ld_id;
            end
            2'b01: begin
               wa_en = 1'b1; wa_id = st_id;
            end
            default: begin
               if (cnt_vec[ld_id] > cnt_vec[st_id]) begin
                  wb_en = 1'b1; wb_id = ld_id;
                  inc_en = 1'b1; inc_id = ld_id;
                  dec_en = 1'b1; dec_id = st_id;
               end else begin
                  wa_en = 1'b1; wa_id = st_id;
                  inc_en = 1'b1; inc_id = st_id;
                  dec_en = 1'b1; dec_id = ld_id;
               end
            end
         endcase
      end
   end

   sset_id_table #(
      .DEPTH(IDT_DEPTH), .ID_W(SID_W), .NRD(NRD), .IDX_W(IDX_W)
   ) u_idt (
      .clk(clk), .rst_n(rst_n), .clr_all(op == OP_CLEAR),
      .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_id(rd_id),
      .wa_en(wa_en), .wa_idx(rd_idx[RP_TL]), .wa_id(wa_id),
      .wb_en(wb_en), .wb_idx(rd_idx[RP_TS]), .wb_id(wb_id),
      .valid_vec(idt_valid_vec)
   );

   logic fetch_fire, fetch_hit, look_hit, lst_rd_valid;
   logic [SID_W-1:0] fetch_sid;
   logic [SEQ_W-1:0] lst_rd_seq;
   assign fetch_fire = (op == OP_FETCH);
   assign fetch_hit  = rd_valid[RP_FE];
   assign fetch_sid  = rd_id[RP_FE];
   assign look_hit   = rd_valid[RP_LK];

   sset_last_store #(
      .DEPTH(LST_DEPTH), .SEQ_W(SEQ_W), .ID_W(SID_W)
   ) u_lst (
      .clk(clk), .rst_n(rst_n), .clr_all(op == OP_CLEAR),
      .sq_en(op == OP_SQUASH), .sq_seq(squash_seq),
      .wr_en(fetch_fire && fetch_hit), .wr_id(fetch_sid), .wr_seq(fetch_seq),
      .kill_en((op == OP_ISSUE) && rd_valid[RP_IS]), .kill_id(rd_id[RP_IS]),
      .kill_seq(issue_seq),
      .rd_id(rd_id[RP_LK]), .rd_valid(lst_rd_valid), .rd_seq(lst_rd_seq),
      .valid_vec(lst_valid_vec), .seq_vec(lst_seq_vec)
   );

   sset_pop_counters #(
      .DEPTH(LST_DEPTH), .CNT_W(CNT_W), .ID_W(SID_W)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .inc_en(inc_en), .inc_id(inc_id), .dec_en(dec_en), .dec_id(dec_id),
      .cnt_vec(cnt_vec)
   );

   assign lookup_dep_seq = (look_hit && lst_rd_valid) ? lst_rd_seq : '0;

   logic unused_pc_bits;
   assign unused_pc_bits = ^{train_store_pc, train_load_pc, fetch_pc, issue_pc, lookup_pc};
endmodule

// File: rtl/sset_predictor_chk.sv
module sset_predictor_chk #(
   parameter int IDT_DEPTH = 64,
   parameter int LST_DEPTH = 16,
   parameter int SEQ_W     = 16,
   parameter int CNT_W     = 3,
   parameter int SID_W     = 4
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            clear_all,
   input logic                            train_valid,
   input logic                            squash_valid,
   input logic [SEQ_W-1:0]                squash_seq,
   input logic                            fetch_valid,
   input logic                            fetch_is_store,
   input logic [SEQ_W-1:0]                fetch_seq,
   input logic                            issue_valid,
   input logic                            issue_is_store,
   input logic [SEQ_W-1:0]                lookup_dep_seq,
   input logic                            look_hit,
   input logic                            fetch_fire,
   input logic                            fetch_hit,
   input logic [SID_W-1:0]                fetch_sid,
   input logic [IDT_DEPTH-1:0]            idt_valid_vec,
   input logic [LST_DEPTH-1:0]            lst_valid_vec,
   input logic [LST_DEPTH-1:0][SEQ_W-1:0] lst_seq_vec,
   input logic [LST_DEPTH-1:0][CNT_W-1:0] cnt_vec
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clear_all |=> (idt_valid_vec == '0 && lst_valid_vec == '0)); // R11

   AST_CLEAR_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      clear_all |=> $stable(cnt_vec)); // R6

   AST_NO_ID_NO_DEP: assert property (@(posedge clk) disable iff (!rst_n)
      !look_hit |-> lookup_dep_seq == '0); // R8

   AST_FETCH_RECORDS: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_fire && fetch_hit) |=>
         (lst_valid_vec[$past(fetch_sid)] && lst_seq_vec[$past(fetch_sid)] == $past(fetch_seq))); // R7

   AST_LOAD_ISSUE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && !issue_is_store && !clear_all && !train_valid && !squash_valid
       && !(fetch_valid && fetch_is_store)) |=> $stable(lst_valid_vec)); // R9

   for (genvar e = 0; e < LST_DEPTH; e++) begin : g_set
      AST_SQUASH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
         (squash_valid && !clear_all && !train_valid && lst_valid_vec[e]
          && lst_seq_vec[e] < squash_seq) |=> !lst_valid_vec[e]); // R10
      AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_vec[e] == CNT_MAX) |=> (cnt_vec[e] != '0)); // R6
      AST_CNT_NO_UNDER: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_vec[e] == '0) |=> (cnt_vec[e] != CNT_MAX)); // R6
   end
endmodule

bind sset_predictor sset_predictor_chk #(
   .IDT_DEPTH(IDT_DEPTH), .LST_DEPTH(LST_DEPTH), .SEQ_W(SEQ_W),
   .CNT_W(CNT_W), .SID_W(SID_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .clear_all(clear_all), .train_valid(train_valid),
   .squash_valid(squash_valid), .squash_seq(squash_seq),
   .fetch_valid(fetch_valid), .fetch_is_store(fetch_is_store), .fetch_seq(fetch_seq),
   .issue_valid(issue_valid), .issue_is_store(issue_is_store),
   .lookup_dep_seq(lookup_dep_seq), .look_hit(look_hit),
   .fetch_fire(fetch_fire), .fetch_hit(fetch_hit), .fetch_sid(fetch_sid),
   .idt_valid_vec(idt_valid_vec), .lst_valid_vec(lst_valid_vec),
   .lst_seq_vec(lst_seq_vec), .cnt_vec(cnt_vec)
);

// File: tb/sset_predictor_bench.sv
module sset_predictor_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clear_all = 1'b0;
   logic        train_valid = 1'b0;
   logic [31:0] train_store_pc = '0, train_load_pc = '0;
   logic        fetch_valid = 1'b0, fetch_is_store = 1'b0;
   logic [31:0] fetch_pc = '0;
   logic [15:0] fetch_seq = '0;
   logic        issue_valid = 1'b0, issue_is_store = 1'b0;
   logic [31:0] issue_pc = '0;
   logic [15:0] issue_seq = '0;
   logic        squash_valid = 1'b0;
   logic [15:0] squash_seq = '0;
   logic [31:0] lookup_pc = '0;
   logic [15:0] lookup_dep_seq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sset_predictor u_sset_predictor (
      .clk(clk), .rst_n(rst_n), .clear_all(clear_all),
      .train_valid(train_valid), .train_store_pc(train_store_pc), .train_load_pc(train_load_pc),
      .fetch_valid(fetch_valid), .fetch_is_store(fetch_is_store), .fetch_pc(fetch_pc),
      .fetch_seq(fetch_seq),
      .issue_valid(issue_valid), .issue_is_store(issue_is_store), .issue_pc(issue_pc),
      .issue_seq(issue_seq),
      .squash_valid(squash_valid), .squash_seq(squash_seq),
      .lookup_pc(lookup_pc), .lookup_dep_seq(lookup_dep_seq)
   );

   // op: 0 idle, 1 violation (pa store, pb load), 2 store fetch, 3 load fetch,
   //     4 store issue, 5 load issue, 6 squash, 7 clear
   typedef struct packed {
      logic [2:0]  op;
      logic [31:0] pa;
      logic [31:0] pb;
      logic [15:0] sq;
      logic [31:0] lpc;
      logic [15:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 37;
   localparam vec_t VECS [0:NV-1] = '{
      '{3'd2, 32'h20, 32'h0,  16'd5,  32'h20,  16'd0,  4'd7},  // R7 no identifier
      '{3'd1, 32'h20, 32'h10, 16'd0,  32'h10,  16'd0,  4'd3},  // R3 new set
      '{3'd2, 32'h20, 32'h0,  16'd10, 32'h10,  16'd10, 4'd7},  // R7 record
      '{3'd3, 32'h10, 32'h0,  16'd11, 32'h112, 16'd10, 4'd2},  // R2 alias, load fetch
      '{3'd5, 32'h10, 32'h0,  16'd10, 32'h10,  16'd10, 4'd9},  // R9 load issue
      '{3'd4, 32'h20, 32'h0,  16'd9,  32'h10,  16'd10, 4'd9},  // R9 other number
      '{3'd4, 32'h20, 32'h0,  16'd10, 32'h10,  16'd0,  4'd9},  // R9 own number
      '{3'd2, 32'h20, 32'h0,  16'd20, 32'h20,  16'd20, 4'd8},  // R8
      '{3'd6, 32'h0,  32'h0,  16'd20, 32'h10,  16'd20, 4'd10}, // R10 equal kept
      '{3'd6, 32'h0,  32'h0,  16'd21, 32'h10,  16'd0,  4'd10}, // R10 below cleared
      '{3'd1, 32'h30, 32'h10, 16'd0,  32'h10,  16'd0,  4'd4},  // R4 store joins
      '{3'd2, 32'h30, 32'h0,  16'd30, 32'h10,  16'd30, 4'd4},
      '{3'd1, 32'h20, 32'h40, 16'd0,  32'h40,  16'd30, 4'd4},  // R4 load joins
      '{3'd1, 32'h54, 32'h14, 16'd0,  32'h14,  16'd0,  4'd3},
      '{3'd2, 32'h54, 32'h0,  16'd40, 32'h14,  16'd40, 4'd3},
      '{3'd1, 32'h54, 32'h10, 16'd0,  32'h14,  16'd40, 4'd5},  // R5 load set larger
      '{3'd2, 32'h54, 32'h0,  16'd50, 32'h10,  16'd50, 4'd5},
      '{3'd0, 32'h0,  32'h0,  16'd0,  32'h14,  16'd40, 4'd5},
      '{3'd1, 32'h20, 32'h14, 16'd0,  32'h14,  16'd50, 4'd5},  // R5 store set larger
      '{3'd1, 32'h68, 32'h18, 16'd0,  32'h18,  16'd0,  4'd3},
      '{3'd1, 32'h7C, 32'h1C, 16'd0,  32'h1C,  16'd0,  4'd3},
      '{3'd1, 32'h7C, 32'h18, 16'd0,  32'h18,  16'd0,  4'd5},  // R5 tie
      '{3'd2, 32'h7C, 32'h0,  16'd60, 32'h18,  16'd60, 4'd5},
      '{3'd0, 32'h0,  32'h0,  16'd0,  32'h1C,  16'd60, 4'd5},
      '{3'd7, 32'h0,  32'h0,  16'd0,  32'h18,  16'd0,  4'd11}, // R11
      '{3'd2, 32'h7C, 32'h0,  16'd61, 32'h1C,  16'd0,  4'd11},
      '{3'd1, 32'h20, 32'h10, 16'd0,  32'h10,  16'd0,  4'd6},  // R6 counters survive clear
      '{3'd1, 32'h54, 32'h24, 16'd0,  32'h24,  16'd0,  4'd6},
      '{3'd1, 32'h54, 32'h10, 16'd0,  32'h10,  16'd0,  4'd6},
      '{3'd2, 32'h54, 32'h0,  16'd70, 32'h24,  16'd0,  4'd6},
      '{3'd0, 32'h0,  32'h0,  16'd0,  32'h10,  16'd70, 4'd6},
      '{3'd1, 32'h90, 32'h10, 16'd0,  32'h10,  16'd70, 4'd6},  // R6 saturate
      '{3'd1, 32'h94, 32'h10, 16'd0,  32'h10,  16'd70, 4'd6},
      '{3'd1, 32'h88, 32'h2C, 16'd0,  32'h2C,  16'd0,  4'd6},
      '{3'd1, 32'h88, 32'h10, 16'd0,  32'h2C,  16'd0,  4'd6},
      '{3'd2, 32'h88, 32'h0,  16'd80, 32'h2C,  16'd0,  4'd6},
      '{3'd0, 32'h0,  32'h0,  16'd0,  32'h10,  16'd80, 4'd6}
   };

   task automatic idle_inputs();
      clear_all = 1'b0; train_valid = 1'b0; fetch_valid = 1'b0; fetch_is_store = 1'b0;
      issue_valid = 1'b0; issue_is_store = 1'b0; squash_valid = 1'b0;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic check(input logic [31:0] pc, input logic [15:0] exp, input string tag);
      lookup_pc = pc;
      #1;
      checks++;
      if (lookup_dep_seq !== exp) begin
         errors++;
         $display("FAIL %s pc=%h actual=%0d expected=%0d", tag, pc, lookup_dep_seq, exp);
      end
   endtask

   task automatic apply(input logic [2:0] op, input logic [31:0] pa, input logic [31:0] pb,
                        input logic [15:0] sq);
      case (op)
         3'd1: begin train_valid = 1'b1; train_store_pc = pa; train_load_pc = pb; end
         3'd2: begin fetch_valid = 1'b1; fetch_is_store = 1'b1; fetch_pc = pa; fetch_seq = sq; end
         3'd3: begin fetch_valid = 1'b1; fetch_pc = pa; fetch_seq = sq; end
         3'd4: begin issue_valid = 1'b1; issue_is_store = 1'b1; issue_pc = pa; issue_seq = sq; end
         3'd5: begin issue_valid = 1'b1; issue_pc = pa; issue_seq = sq; end
         3'd6: begin squash_valid = 1'b1; squash_seq = sq; end
         3'd7: clear_all = 1'b1;
         default: ;
      endcase
      tick();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(32'h10, 16'd0, "R1 lookup during reset");
      rst_n = 1'b1;
      @(negedge clk);
      check(32'h20, 16'd0, "R1 lookup after reset");

      for (int i = 0; i < NV; i++) begin
         apply(VECS[i].op, VECS[i].pa, VECS[i].pb, VECS[i].sq);
         check(VECS[i].lpc, VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
      end

      // R12 squash beats store fetch
      squash_valid = 1'b1; squash_seq = 16'd100;
      fetch_valid = 1'b1; fetch_is_store = 1'b1; fetch_pc = 32'h20; fetch_seq = 16'd90;
      tick();
      check(32'h10, 16'd0, "R12 squash over fetch");

      apply(3'd2, 32'h20, 32'h0, 16'd90);
      check(32'h10, 16'd90, "R7 fetch after squash");

      // R12 violation beats store issue
      train_valid = 1'b1; train_store_pc = 32'h20; train_load_pc = 32'h10;
      issue_valid = 1'b1; issue_is_store = 1'b1; issue_pc = 32'h20; issue_seq = 16'd90;
      tick();
      check(32'h10, 16'd90, "R12 violation over issue");

      // R12 store issue beats store fetch
      issue_valid = 1'b1; issue_is_store = 1'b1; issue_pc = 32'h20; issue_seq = 16'd90;
      fetch_valid = 1'b1; fetch_is_store = 1'b1; fetch_pc = 32'h20; fetch_seq = 16'd95;
      tick();
      check(32'h10, 16'd0, "R12 issue over fetch");

      // R12 clear beats violation
      clear_all = 1'b1;
      train_valid = 1'b1; train_store_pc = 32'hA0; train_load_pc = 32'hA4;
      tick();
      check(32'h10, 16'd0, "R11 clear empties tables");
      apply(3'd2, 32'hA0, 32'h0, 16'd3);
      check(32'hA4, 16'd0, "R12 clear over violation");

      // R12 load issue is not a request and does not block a store fetch
      apply(3'd1, 32'h20, 32'h10, 16'd0);
      issue_valid = 1'b1; issue_is_store = 1'b0; issue_pc = 32'h10; issue_seq = 16'd7;
      fetch_valid = 1'b1; fetch_is_store = 1'b1; fetch_pc = 32'h20; fetch_seq = 16'd7;
      tick();
      check(32'h10, 16'd7, "R12 load issue does not block");

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule